// File: doc/BRIEF.md
# Packed Byte Absolute-Difference and Average Unit

This execution unit takes two 64-bit operands and treats each one as eight independent unsigned byte lanes. Each valid request carries a 6-bit function code that picks one of three operations. Two of them write a vector result: the per-lane absolute difference, and the per-lane average with ties rounded up. The third finds the per-lane absolute difference and adds it into one of eight 24-bit lane accumulators. This is the inner step of a sum-of-absolute-differences search, such as motion estimation.

The vector result passes through a register. A result-valid pulse marks the cycle after each accepted vector request. The accumulators change only when a valid accumulate request arrives. All eight are driven out on a flat bus at all times.

Top module: `byte_sad_unit`

## Requirements
- R1: Lane k (k = 0..7) takes bits [8k+7:8k] of each operand and writes the same bits of the result. No lane affects any other lane.
- R2: For function code 6'b001001, each result lane is the larger of the two operand bytes minus the smaller one, as an unsigned 8-bit value.
- R3: For function code 6'b001000, each result lane is (a + b + 1) >> 1, computed with a 9-bit sum. This rounds half up, so 0xFF with 0xFF gives 0xFF.
- R4: For function code 6'b110101, each lane's absolute difference is zero-extended and added to that lane's 24-bit accumulator. Accumulator k is bits [24k+23:24k] of the accumulator bus. This operation does not raise result-valid.
- R5: Accumulator additions wrap modulo 2^24 and do not saturate.
- R6: A valid request with any other function code changes neither the result, result-valid nor the accumulators.
- R7: Result-valid is high exactly in the cycle after a valid average or absolute-difference request. The result register holds its value in all other cycles.
- R8: The accumulators do not change when the valid strobe is low, whatever the function code.
- R9: A synchronous active-high reset clears the result register, result-valid and all eight accumulators.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| func | input | 6 | Function code |
| opnd_a | input | 64 | First operand, eight byte lanes |
| opnd_b | input | 64 | Second operand, eight byte lanes |
| res_data | output | 64 | Registered vector result |
| res_valid | output | 1 | Result-valid pulse |
| acc_bus | output | 192 | Eight 24-bit lane accumulators |

## Verification
The lane assertions assume that both operand buses carry known values whenever they are evaluated. They are guarded so that X operands are skipped rather than flagged. The bench therefore drives defined operand values from time zero.

The clocked assertions assume that reset is held for at least one clock before the first request. The bench holds reset for several cycles. The stimulus mixes all three valid codes with an unused code and with idle cycles. It also runs a long stretch of back-to-back accumulates, so that the 24-bit wrap happens under ordinary operation.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int FUNC_W = 6;
  localparam logic [FUNC_W-1:0] FN_AVG    = 6'b001000;
  localparam logic [FUNC_W-1:0] FN_ABSD   = 6'b001001;
  localparam logic [FUNC_W-1:0] FN_SADACC = 6'b110101;

  typedef enum logic [1:0] {OP_NONE, OP_AVG, OP_ABSD, OP_ACC} op_e;

  function automatic op_e decode_op(input logic vld, input logic [FUNC_W-1:0] f);
    op_e r;
    r = OP_NONE;
    if (vld) begin
      case (f)
        FN_AVG:    r = OP_AVG;
        FN_ABSD:   r = OP_ABSD;
        FN_SADACC: r = OP_ACC;
        default:   r = OP_NONE;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/sad_lane.sv
module sad_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] absd,
  output logic [LANE_W-1:0] avg
);
  localparam int SUM_W = LANE_W + 1;

  logic [SUM_W-1:0] sum_r;
  logic             a_ge_b;

  always_comb begin
    a_ge_b = (a >= b);
    absd   = a_ge_b ? (a - b) : (b - a);
    sum_r  = {1'b0, a} + {1'b0, b} + SUM_W'(1);
    avg    = sum_r[SUM_W-1:1];
  end

  // Difference added back to the smaller operand must give the larger one.
  always_comb begin
    if (!$isunknown({a, b})) begin
      assert_absd_sum_R2: assert ((a_ge_b ? ({1'b0, b} + {1'b0, absd}) : ({1'b0, a} + {1'b0, absd}))
                                  == (a_ge_b ? {1'b0, a} : {1'b0, b}))
        else $error("absolute difference inconsistent");
      assert_avg_range_R3: assert ((avg >= (a_ge_b ? b : a)) && (avg <= (a_ge_b ? a : b)))
        else $error("average out of operand range");
    end
  end
endmodule

// File: rtl/sad_acc_bank.sv
module sad_acc_bank #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    add_en,
  input  logic [LANES*LANE_W-1:0] deltas,
  output logic [LANES*ACC_W-1:0]  acc
);
  localparam int PAD_W = ACC_W - LANE_W;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_acc
      logic [ACC_W-1:0] acc_q;
      always_ff @(posedge clk) begin
        if (rst)
          acc_q <= '0;
        else if (add_en)
          acc_q <= acc_q + {{PAD_W{1'b0}}, deltas[g*LANE_W +: LANE_W]};
      end
      assign acc[g*ACC_W +: ACC_W] = acc_q;
    end
  endgenerate

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !add_en |=> $stable(acc))
    else $error("accumulator moved without an add");

  assert_acc_clear_R9: assert property (@(posedge clk)
    rst |=> (acc == '0))
    else $error("accumulators not cleared by reset");
endmodule

// File: rtl/byte_sad_unit.sv
module byte_sad_unit
  import sad_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [5:0]              func,
  input  logic [LANES*LANE_W-1:0] opnd_a,
  input  logic [LANES*LANE_W-1:0] opnd_b,
  output logic [LANES*LANE_W-1:0] res_data,
  output logic                    res_valid,
  output logic [LANES*ACC_W-1:0]  acc_bus
);
  localparam int VEC_W = LANES * LANE_W;

  op_e              op;
  logic [VEC_W-1:0] absd_v;
  logic [VEC_W-1:0] avg_v;
  logic             vec_req;

  assign op      = decode_op(in_valid, func);
  assign vec_req = (op == OP_AVG) || (op == OP_ABSD);

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      sad_lane #(.LANE_W(LANE_W)) u_lane (
        .a    (opnd_a[g*LANE_W +: LANE_W]),
        .b    (opnd_b[g*LANE_W +: LANE_W]),
        .absd (absd_v[g*LANE_W +: LANE_W]),
        .avg  (avg_v[g*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= vec_req;
      if (op == OP_AVG)
        res_data <= avg_v;
      else if (op == OP_ABSD)
        res_data <= absd_v;
    end
  end

  sad_acc_bank #(.LANES(LANES), .LANE_W(LANE_W), .ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .add_en (op == OP_ACC),
    .deltas (absd_v),
    .acc    (acc_bus)
  );

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (func == FN_AVG || func == FN_ABSD)) |=> res_valid)
    else $error("missing result-valid");

  assert_valid_source_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && (func == FN_AVG || func == FN_ABSD)))
    else $error("spurious result-valid");

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && (func == FN_AVG || func == FN_ABSD)) |=> $stable(res_data))
    else $error("result changed without a vector request");

  assert_no_valid_on_acc_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && func == FN_SADACC) |=> !res_valid)
    else $error("accumulate raised result-valid");

  assert_reset_clear_R9: assert property (@(posedge clk)
    rst |=> (res_data == '0 && !res_valid))
    else $error("result not cleared by reset");
endmodule

// File: tb/sim_byte_sad_unit.sv
`timescale 1ns/1ps
module sim_byte_sad_unit;
  localparam int L = 8;
  localparam int AW = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [5:0]  func = 6'd0;
  logic [63:0] a = 64'd0;
  logic [63:0] b = 64'd0;
  logic [63:0]  res_data;
  logic         res_valid;
  logic [191:0] acc_bus;

  int errs = 0;
  int checks = 0;
  bit live = 0;

  byte_sad_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func(func),
    .opnd_a(a), .opnd_b(b), .res_data(res_data), .res_valid(res_valid), .acc_bus(acc_bus)
  );

  always #2 clk = ~clk;

  // behavioural reference model
  logic [63:0] m_res = 64'd0;
  logic        m_val = 1'b0;
  logic [23:0] m_acc [L];
  string       m_tag = "R9";

  initial for (int i = 0; i < L; i++) m_acc[i] = 24'd0;

  always @(posedge clk) begin
    if (rst) begin
      m_res = 64'd0; m_val = 1'b0; m_tag = "R9";
      for (int i = 0; i < L; i++) m_acc[i] = 24'd0;
    end else begin
      m_val = 1'b0;
      if (in_valid) begin
        for (int i = 0; i < L; i++) begin
          int x, y, d;
          x = a[i*8 +: 8];
          y = b[i*8 +: 8];
          d = (x > y) ? x - y : y - x;
          if (func == 6'b001001) m_res[i*8 +: 8] = d[7:0];
          else if (func == 6'b001000) m_res[i*8 +: 8] = 8'((x + y + 1) / 2);
          else if (func == 6'b110101) m_acc[i] = m_acc[i] + 24'(d);
        end
        if (func == 6'b001001) begin m_val = 1'b1; m_tag = "R2"; end
        if (func == 6'b001000) begin m_val = 1'b1; m_tag = "R3"; end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      chk("R7", {63'd0, res_valid}, {63'd0, m_val});
      chk(m_tag, res_data, m_res);
      for (int i = 0; i < L; i++) chk("R4", {40'd0, acc_bus[i*AW +: AW]}, {40'd0, m_acc[i]});
    end
  end

  task automatic issue(input logic [5:0] f, input logic [63:0] x, input logic [63:0] y);
    @(negedge clk);
    in_valid = 1'b1; func = f; a = x; b = y;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [63:0] lfsr;
    logic [63:0] held;
    logic [23:0] snap [L];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    live = 1;
    // R9 reset state
    chk("R9", res_data, 64'd0);
    chk("R9", {63'd0, res_valid}, 64'd0);
    chk("R9", acc_bus[63:0], 64'd0);

    // R1 lane placement with distinct lanes, R2 absolute difference
    issue(6'b001001, 64'h0706050403020100, 64'h0001020304050607);
    idle();
    chk("R1", res_data, 64'h0705030101030507);
    chk("R7", {63'd0, res_valid}, 64'd1);
    idle();
    chk("R7", {63'd0, res_valid}, 64'd0);
    chk("R7", res_data, 64'h0705030101030507);

    // R3 rounding average incl. ties and top values
    issue(6'b001000, 64'h00FFFE0101020300, 64'h01FFFF0001030300);
    idle();
    chk("R3", res_data, 64'h01FFFF0101030300);

    // R6 unused function code ignored
    held = res_data;
    issue(6'b001010, 64'hFFFFFFFFFFFFFFFF, 64'd0);
    idle();
    chk("R6", res_data, held);
    chk("R6", {63'd0, res_valid}, 64'd0);
    chk("R6", acc_bus[63:0], 64'd0);

    // R4 accumulate, no vector result
    issue(6'b110101, 64'h0A00000000000003, 64'h000000000000000A);
    idle();
    chk("R4", {40'd0, acc_bus[0 +: AW]}, 64'd7);
    chk("R4", {40'd0, acc_bus[7*AW +: AW]}, 64'd10);
    chk("R4", {63'd0, res_valid}, 64'd0);
    chk("R4", res_data, held);

    // R8 accumulate code without strobe
    for (int i = 0; i < L; i++) snap[i] = acc_bus[i*AW +: AW];
    @(negedge clk); in_valid = 1'b0; func = 6'b110101; a = 64'hFFFFFFFFFFFFFFFF; b = 64'd0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < L; i++) chk("R8", {40'd0, acc_bus[i*AW +: AW]}, {40'd0, snap[i]});

    // mixed pattern run, compared every clock (R2, R3, R4, R6, R7)
    lfsr = 64'h9E3779B97F4A7C15;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      case (lfsr[2:0])
        3'd0, 3'd1: issue(6'b001001, lfsr, {lfsr[31:0], lfsr[63:32]});
        3'd2, 3'd3: issue(6'b001000, lfsr, ~lfsr);
        3'd4, 3'd5: issue(6'b110101, lfsr, {lfsr[7:0], lfsr[63:8]});
        3'd6:       issue(6'b000111, lfsr, 64'd0);
        default:    idle();
      endcase
    end
    idle();

    // R9 reset mid run clears everything
    do_reset();
    chk("R9", acc_bus[63:0], 64'd0);
    chk("R9", acc_bus[191:128], 64'd0);
    chk("R9", res_data, 64'd0);

    // R5 wrap: 65794 * 255 mod 2^24 = 254
    for (int k = 0; k < 65794; k++) issue(6'b110101, 64'hFFFFFFFFFFFFFFFF, 64'd0);
    idle();
    for (int i = 0; i < L; i++) chk("R5", {40'd0, acc_bus[i*AW +: AW]}, 64'd254);

    idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #600000;
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule